// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR SDRAM and drives the clock-enable, command strobes, bank select and address pins through the mandatory bring-up order after a synchronous reset. It first holds clock-enable low with a no-op on the command pins for a power-up wait. That wait is given in microseconds and is converted to clock cycles through a clock-frequency parameter. It then raises clock-enable and issues, in a fixed order, the commands that bring the device to a usable state. The order is an extended mode write that turns the DLL on, then a main mode write that resets the DLL, then a precharge of all banks, then a run of auto-refresh commands, and last the operating mode write.

Each command is followed by its own minimum gap of no-op cycles. A separate counter tracks the DLL lock time from the DLL-reset write, so the completion flag never rises before the DLL has had its lock window. Once the flag is up, the pins rest at no-op with clock-enable high, and normal traffic can take over. The operating mode word, the extended mode word, the gaps, the refresh count and the lock time are all parameters.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While `rst` is high, every clock leaves `mem_cke` low, the command strobes {cs_n,ras_n,cas_n,we_n} at the no-op code 0111, `mem_ba` and `mem_addr` at zero and `init_done` low.
- R2: After `rst` is released, `mem_cke` stays low with no-op for exactly PWRUP_US*CLK_MHZ clock cycles.
- R3: `mem_cke` then goes high and stays high. The pins hold no-op for CKE_LEAD cycles before the first command.
- R4: The first command is a mode write (strobes 0000) with `mem_ba` = 01 and `mem_addr` = EXT_MODE with bit 0 forced low, which turns the DLL on.
- R5: The second command, TMRD cycles later, is a mode write with `mem_ba` = 00 and `mem_addr` = FINAL_MODE with bit 8 forced high, which resets the DLL.
- R6: The third command, TMRD cycles later, is a precharge (strobes 0010) with address bit 10 high, which precharges all banks. `mem_ba` and the other address bits are zero.
- R7: TRP cycles after the precharge, exactly NUM_REFRESH auto-refresh commands (strobes 0001) are issued, each TRFC cycles after the one before.
- R8: TRFC cycles after the last refresh, the final mode write is issued with `mem_ba` = 00 and `mem_addr` = FINAL_MODE with bit 8 forced low.
- R9: Every cycle between commands carries no-op with zero bank and address. Mode writes are followed by TMRD cycles and the precharge by TRP cycles before the next command.
- R10: Each auto-refresh is followed by TRFC cycles of no-op before the next command.
- R11: `init_done` rises at the later of (final mode write + TMRD) and (DLL-reset write + DLL_LOCK_CYC). It then stays high, with no-op and `mem_cke` high.
- R12: Raising `rst` at any point returns the pins to the R1 state on the next clock. The next release restarts the whole order, including a fresh lock wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank select |
| mem_addr | output | ADDR_W | Address bus, carries the mode words |
| init_done | output | 1 | High once bring-up is complete |

## Verification
All pin outputs are registered from the step state, so a wrong step, gap count or refresh count shows up at the pins one clock after the mistake. It appears as a command on the wrong cycle, with the wrong strobes or with a wrong mode word. A lock counter that starts late or never restarts after reset is not visible as a command. It shows only as `init_done` rising on the wrong cycle, which can be up to DLL_LOCK_CYC cycles after the last command. For that reason the bench compares every pin on every cycle against a timeline it computes itself. It also runs two parameter sets, so that each of the two terms of the completion time is the later one in one of them.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // Strobe order {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_MODE = 4'b0000;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;

  // Address bit positions the memory decodes
  localparam int DLL_OFF_BIT = 0;
  localparam int DLL_RST_BIT = 8;
  localparam int ALL_BANK_BIT = 10;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_CKE,
    ST_EXTMODE,
    ST_DLLRST,
    ST_PREALL,
    ST_REFRESH,
    ST_OPMODE,
    ST_DONE
  } step_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= W'(INIT);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // A loaded count must hold off expiry for at least one cycle
  p_load_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (load_i && val_i != '0) |=> !zero_o);

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ok_o
);

  localparam int LW = $clog2(LOCK_CYC + 1);

  logic          armed_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= LW'(LOCK_CYC - 1);
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ok_o = armed_q && (cnt_q == '0);

  // Once the lock window has elapsed it stays elapsed
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (ok_o && !start_i) |=> ok_o);

  // Starting the window never reports lock on the next cycle unless it is one cycle long
  p_lock_start_r5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (ok_o == (LOCK_CYC == 1)));

endmodule

// File: rtl/ddr_init_drive.sv
module ddr_init_drive
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                BANK_W     = 2,
  parameter logic [ADDR_W-1:0] EXT_MODE   = '0,
  parameter logic [ADDR_W-1:0] FINAL_MODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  step_t             step_i,
  input  logic              fresh_i,
  input  logic              done_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] ONE_HOT_RST = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] ONE_HOT_AP  = ADDR_W'(1) << ALL_BANK_BIT;
  localparam logic [ADDR_W-1:0] ONE_HOT_DLL = ADDR_W'(1) << DLL_OFF_BIT;
  localparam logic [ADDR_W-1:0] EXT_WORD    = EXT_MODE & ~ONE_HOT_DLL;
  localparam logic [ADDR_W-1:0] RST_WORD    = FINAL_MODE | ONE_HOT_RST;
  localparam logic [ADDR_W-1:0] OP_WORD     = FINAL_MODE & ~ONE_HOT_RST;

  logic [3:0]        cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (fresh_i) begin
      case (step_i)
        ST_EXTMODE: begin
          cmd_d  = CMD_MODE;
          ba_d   = BANK_W'(1);
          addr_d = EXT_WORD;
        end
        ST_DLLRST: begin
          cmd_d  = CMD_MODE;
          addr_d = RST_WORD;
        end
        ST_PREALL: begin
          cmd_d  = CMD_PRE;
          addr_d = ONE_HOT_AP;
        end
        ST_REFRESH: cmd_d = CMD_REF;
        ST_OPMODE: begin
          cmd_d  = CMD_MODE;
          addr_d = OP_WORD;
        end
        default: cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_o  <= 1'b0;
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cke_o  <= (step_i != ST_PWRUP);
      cmd_o  <= cmd_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
      done_o <= done_i;
    end
  end

  p_pre_all_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PRE) |-> addr_o[ALL_BANK_BIT]);

  p_ext_dll_on_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MODE && ba_o == BANK_W'(1)) |-> !addr_o[DLL_OFF_BIT]);

endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq
  import ddr_init_pkg::*;
#(
  parameter int                CLK_MHZ      = 125,
  parameter int                PWRUP_US     = 200,
  parameter int                CKE_LEAD     = 2,
  parameter int                TMRD         = 2,
  parameter int                TRP          = 4,
  parameter int                TRFC         = 15,
  parameter int                NUM_REFRESH  = 2,
  parameter int                DLL_LOCK_CYC = 200,
  parameter int                ADDR_W       = 12,
  parameter int                BANK_W       = 2,
  parameter logic [ADDR_W-1:0] EXT_MODE     = '0,
  parameter logic [ADDR_W-1:0] FINAL_MODE   = 12'h032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int PWR_CYC = PWRUP_US * CLK_MHZ;
  localparam int GAP_MAX = imax(imax(CKE_LEAD, TMRD), imax(TRP, TRFC));
  localparam int TW      = $clog2(imax(PWR_CYC, GAP_MAX) + 1);
  localparam int RW      = $clog2(NUM_REFRESH + 1);

  step_t         step_q, step_d;
  logic          fresh_q, fresh_d;
  logic [RW-1:0] nref_q, nref_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          lock_ok;
  logic [3:0]    cmd;

  always_comb begin
    step_d   = step_q;
    fresh_d  = 1'b0;
    nref_d   = nref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (tmr_zero) begin
      unique case (step_q)
        ST_PWRUP: begin
          step_d   = ST_CKE;
          tmr_load = 1'b1;
          tmr_val  = TW'(CKE_LEAD - 1);
        end
        ST_CKE: begin
          step_d   = ST_EXTMODE;
          fresh_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(TMRD - 1);
        end
        ST_EXTMODE: begin
          step_d   = ST_DLLRST;
          fresh_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(TMRD - 1);
        end
        ST_DLLRST: begin
          step_d   = ST_PREALL;
          fresh_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRP - 1);
        end
        ST_PREALL: begin
          step_d   = ST_REFRESH;
          fresh_d  = 1'b1;
          nref_d   = RW'(1);
          tmr_load = 1'b1;
          tmr_val  = TW'(TRFC - 1);
        end
        ST_REFRESH: begin
          fresh_d  = 1'b1;
          tmr_load = 1'b1;
          if (nref_q < RW'(NUM_REFRESH)) begin
            nref_d  = nref_q + 1'b1;
            tmr_val = TW'(TRFC - 1);
          end else begin
            step_d  = ST_OPMODE;
            tmr_val = TW'(TMRD - 1);
          end
        end
        ST_OPMODE: step_d = ST_DONE;
        ST_DONE:   step_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_PWRUP;
      fresh_q <= 1'b0;
      nref_q  <= '0;
    end else begin
      step_q  <= step_d;
      fresh_q <= fresh_d;
      nref_q  <= nref_d;
    end
  end

  ddr_init_timer #(
    .W    (TW),
    .INIT (PWR_CYC - 1)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  ddr_init_lock #(
    .LOCK_CYC (DLL_LOCK_CYC)
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .start_i (step_q == ST_DLLRST && fresh_q),
    .ok_o    (lock_ok)
  );

  ddr_init_drive #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .EXT_MODE   (EXT_MODE),
    .FINAL_MODE (FINAL_MODE)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step_q),
    .fresh_i (fresh_q),
    .done_i  (step_q == ST_DONE && lock_ok),
    .cke_o   (mem_cke),
    .cmd_o   (cmd),
    .ba_o    (mem_ba),
    .addr_o  (mem_addr),
    .done_o  (init_done)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

  // Pin-level checks
  p_nop_while_cke_low_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_cke |-> (cmd == CMD_NOP));

  p_cke_stays_high_r3: assert property (@(posedge clk) disable iff (rst)
    mem_cke |=> mem_cke);

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_done_idle_pins_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (mem_cke && cmd == CMD_NOP));

  p_done_after_lock_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |-> lock_ok);

  p_refresh_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  p_single_refresh_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_REFRESH) |-> (nref_q != '0 && nref_q <= RW'(NUM_REFRESH)));

  if (TMRD > 1) begin : g_mode_gap
    p_mode_gap_r9: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_MODE) |=> (cmd == CMD_NOP));
  end

endmodule

// File: tb/ddr_bringup_seq_test.sv
module ddr_bringup_seq_test;

  localparam int LEAD = 2;
  localparam int MRD  = 2;
  localparam int RP   = 4;
  localparam int RFC  = 15;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic [1:0]  ba_a;
  logic [11:0] ad_a;
  logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0]  ba_b;
  logic [11:0] ad_b;

  ddr_bringup_seq uut (
    .clk(clk), .rst(rst), .mem_cke(cke_a), .mem_cs_n(cs_a), .mem_ras_n(ras_a),
    .mem_cas_n(cas_a), .mem_we_n(we_a), .mem_ba(ba_a), .mem_addr(ad_a),
    .init_done(done_a));

  ddr_bringup_seq #(
    .CLK_MHZ(1), .PWRUP_US(30), .NUM_REFRESH(3), .DLL_LOCK_CYC(10),
    .FINAL_MODE(12'h14B)
  ) uut_b (
    .clk(clk), .rst(rst), .mem_cke(cke_b), .mem_cs_n(cs_b), .mem_ras_n(ras_b),
    .mem_cas_n(cas_b), .mem_we_n(we_b), .mem_ba(ba_b), .mem_addr(ad_b),
    .init_done(done_b));

  localparam logic [19:0] RESET_VEC = {1'b0, 1'b0, 4'b0111, 2'b00, 12'h000};

  function automatic logic [19:0] got_vec(input int i);
    if (i == 0) return {done_a, cke_a, cs_a, ras_a, cas_a, we_a, ba_a, ad_a};
    return {done_b, cke_b, cs_b, ras_b, cas_b, we_b, ba_b, ad_b};
  endfunction

  function automatic int pw(input int i);   return (i == 0) ? 25000 : 30; endfunction
  function automatic int nrf(input int i);  return (i == 0) ? 2 : 3;      endfunction
  function automatic int lck(input int i);  return (i == 0) ? 200 : 10;   endfunction
  function automatic logic [11:0] fin(input int i);
    return (i == 0) ? 12'h032 : 12'h14B;
  endfunction

  // Event cycles: 0 ext write, 1 dll reset, 2 precharge, 3 first refresh, 4 final write, 5 done
  function automatic int ev(input int i, input int e);
    int x, d, r0, m, dn;
    x  = pw(i) + LEAD;
    d  = x + MRD;
    r0 = d + MRD + RP;
    m  = r0 + nrf(i) * RFC;
    dn = (m + MRD > d + lck(i)) ? m + MRD : d + lck(i);
    case (e)
      0: return x;
      1: return d;
      2: return d + MRD;
      3: return r0;
      4: return m;
      default: return dn;
    endcase
  endfunction

  function automatic logic [19:0] exp_vec(input int i, input int k);
    logic [3:0]  c;
    logic [1:0]  b;
    logic [11:0] a;
    c = 4'b0111; b = 2'b00; a = 12'h000;
    if (k == ev(i, 0)) begin c = 4'b0000; b = 2'b01; end
    else if (k == ev(i, 1)) begin c = 4'b0000; a = fin(i) | 12'h100; end
    else if (k == ev(i, 2)) begin c = 4'b0010; a = 12'h400; end
    else if (k >= ev(i, 3) && k < ev(i, 4) && ((k - ev(i, 3)) % RFC) == 0) c = 4'b0001;
    else if (k == ev(i, 4)) begin c = 4'b0000; a = fin(i) & ~12'h100; end
    return {(k >= ev(i, 5)), (k >= pw(i)), c, b, a};
  endfunction

  function automatic string tag_of(input int i, input int k);
    if (k < pw(i))         return "R2";
    if (k < ev(i, 0))      return "R3";
    if (k == ev(i, 0))     return "R4";
    if (k == ev(i, 1))     return "R5";
    if (k == ev(i, 2))     return "R6";
    if (k >= ev(i, 3) && k < ev(i, 4) && ((k - ev(i, 3)) % RFC) == 0) return "R7";
    if (k == ev(i, 4))     return "R8";
    if (k > ev(i, 3) && k < ev(i, 4)) return "R10";
    if (k < ev(i, 4))      return "R9";
    return "R11";
  endfunction

  task automatic check_vec(input int i, input int k, input logic [19:0] expv, input string tag);
    logic [19:0] g;
    g = got_vec(i);
    n_cmp++;
    if (g !== expv) begin
      n_bad++;
      $display("FAIL %s inst%0d step %0d: actual %h expected %h", tag, i, k, g, expv);
    end
  endtask

  task automatic hold_reset(input int cycles, input string tag);
    rst = 1'b1;
    for (int h = 0; h < cycles; h++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) check_vec(i, -1, RESET_VEC, tag);
    end
  endtask

  task automatic run_seq(input int steps);
    rst = 1'b0;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) check_vec(i, k, exp_vec(i, k), tag_of(i, k));
    end
  endtask

  localparam int FULL = 25204 + 24;

  initial begin
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);
    hold_reset(3, "R1");
    // full bring-up; instance A finishes on the lock term, B on the mode-write gap
    run_seq(FULL);
    // random abort before clock-enable rises
    hold_reset(1 + int'($urandom_range(4)), "R12");
    run_seq(20 + int'($urandom_range(24000)));
    // random abort inside the lock window of instance A
    hold_reset(1 + int'($urandom_range(4)), "R12");
    run_seq(25005 + int'($urandom_range(190)));
    // directed abort one cycle after the final mode write of A
    hold_reset(2, "R12");
    run_seq(25041);
    // full run again: lock wait must restart from scratch (R12, R11)
    hold_reset(1, "R12");
    run_seq(FULL);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion before it", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule